// File: doc/BRIEF.md
# Segmented Arbitrary Transmit Pulse Shaper

This block turns a stream of bipolar symbol requests into a sequence of signed amplitude samples for a line-driver DAC. Every symbol period is cut into eight equal time slices. The level of each slice comes from its own host-programmable sign-magnitude word. Software can therefore set overshoot, main amplitude and undershoot freely to suit a custom line build-out.

A segment-rate strobe steps the block through slices 1 to 8. At the start of each symbol the block captures a new request: positive mark, negative mark or space. On the same boundary it also captures the shaping-mode enable and copies the host-written words into a working bank. A pulse in progress therefore never mixes old and new settings. A negative mark plays the programmed shape with every sign flipped. A space, or any symbol sent while shaping is disabled, produces a flat zero line.

Top module: `seg_pulse_shaper`

## Requirements
- R1: After reset, every segment word reads 0x00, `sample_out` is 0 and `seg_num` is 7, so the first strobe opens a new symbol.
- R2: A write to address 0x8+k (k = 0..7) stores the 8-bit word for segment k+1. A read of that address returns the same byte, sign bit included, without delay.
- R3: Writes to addresses 0x0 to 0x7 are ignored, and reads of those addresses return 0x00.
- R4: Each cycle with `seg_stb` high advances `seg_num` by one. From 7 (segment 8) it wraps to 0 (segment 1). Without a strobe, `seg_num` holds.
- R5: `sym_req` is sampled only on a strobe that wraps `seg_num` from 7 to 0. The codes are 01 positive mark, 10 negative mark, and 00 or 11 space. A change of `sym_req` at any other time has no effect on the current pulse.
- R6: Segment word bit 7 is the sign and bits 6:0 are the magnitude. For a positive mark, `sample_out` is +magnitude when the sign is 1 and −magnitude when it is 0, in 8-bit two's complement.
- R7: For a negative mark, every segment outputs the negation of its positive-mark value.
- R8: For a space, every segment outputs 0.
- R9: `t1_mode` is sampled at the wrap strobe. A symbol that starts with it low outputs 0 on all eight segments.
- R10: A segment write takes effect at the next wrap strobe. A write in the same cycle as a wrap strobe applies only from the boundary after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Segment-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Register write enable |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| t1_mode | input | 1 | Enables programmable shaping; sampled at each symbol start |
| seg_stb | input | 1 | One-cycle segment-rate strobe |
| sym_req | input | 2 | Symbol request: 01 positive, 10 negative, 00/11 space |
| seg_num | output | 3 | Current segment, 0..7 for segments 1..8 |
| sample_out | output | 8 | Signed sample for the DAC |

## Verification
The bench uses the default parameters: eight segments, 8-bit words and a segment base address of 0x8. This puts the full ±127 magnitude range within reach, together with the zero-magnitude cases of both signs. The 4-bit address space covers both the decoded bank and the undecoded lower half, so ignored writes can be observed through reads. With eight segments per symbol, the tests can change the request and the register contents in the middle of a pulse and on the exact wrap cycle. They can then see at the output which symbol each change first reaches.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [1:0] {
    SYM_SPACE = 2'b00,
    SYM_POS   = 2'b01,
    SYM_NEG   = 2'b10,
    SYM_RSV   = 2'b11
  } sym_e;
endpackage

// File: rtl/shp_rst_sync.sv
module shp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/shp_regbank.sv
module shp_regbank #(
  parameter int NUM_SEG  = 8,
  parameter int WORD_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int SEG_BASE = 8,
  localparam int IDX_W   = $clog2(NUM_SEG),
  localparam int BANK_W  = NUM_SEG * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load,
  output logic [WORD_W-1:0] rdata,
  output logic [BANK_W-1:0] active_flat
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [BANK_W-1:0] shadow_flat;
  logic [BANK_W-1:0] active_q;
  logic [BANK_W-1:0] active_d;

  always_comb begin
    hit = (int'(addr) >= SEG_BASE) && (int'(addr) < SEG_BASE + NUM_SEG);
    idx = IDX_W'(int'(addr) - SEG_BASE);
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [WORD_W-1:0] shd_q;
    logic [WORD_W-1:0] shd_d;
    logic              shd_en;

    always_comb begin
      shd_en = we && hit && (idx == IDX_W'(g));
      shd_d  = shd_en ? wdata : shd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shd_q <= '0;
      else        shd_q <= shd_d;
    end

    assign shadow_flat[g*WORD_W +: WORD_W] = shd_q;

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit && idx == IDX_W'(g)) |=> (shd_q == $past(wdata))); // R2
  end

  always_comb begin
    rdata = hit ? shadow_flat[idx*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    active_d = load ? shadow_flat : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  assign active_flat = active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q)); // R10
  AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q == $past(shadow_flat))); // R10
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0)); // R3
endmodule

// File: rtl/shp_seq.sv
module shp_seq #(
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_stb,
  input  logic [1:0]       sym_req,
  input  logic             t1_mode,
  output logic [IDX_W-1:0] seg_idx,
  output logic [1:0]       sym_cur,
  output logic             mode_cur,
  output logic             wrap
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       sym_q, sym_d;
  logic             mode_q, mode_d;

  always_comb begin
    wrap   = seg_stb && (idx_q == LAST);
    idx_d  = idx_q;
    sym_d  = sym_q;
    mode_d = mode_q;
    if (seg_stb) begin
      idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
    if (wrap) begin
      sym_d  = sym_req;
      mode_d = t1_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= LAST;
      sym_q  <= shp_pkg::SYM_SPACE;
      mode_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      sym_q  <= sym_d;
      mode_q <= mode_d;
    end
  end

  assign seg_idx  = idx_q;
  assign sym_cur  = sym_q;
  assign mode_cur = mode_q;

  AST_SEG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_stb && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1)); // R4
  AST_SEG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_stb && idx_q == LAST) |=> (idx_q == '0)); // R4
  AST_SEG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_stb |=> $stable(idx_q)); // R4
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_stb && idx_q == LAST) |=> ($stable(sym_q) && $stable(mode_q))); // R5
endmodule

// File: rtl/shp_level.sv
module shp_level #(
  parameter int NUM_SEG = 8,
  parameter int WORD_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int MAG_W  = WORD_W - 1,
  localparam int BANK_W = NUM_SEG * WORD_W
) (
  input  logic [BANK_W-1:0] active_flat,
  input  logic [IDX_W-1:0]  seg_idx,
  input  logic [1:0]        sym_cur,
  input  logic              mode_cur,
  output logic [WORD_W-1:0] level
);
  import shp_pkg::*;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] mag_ext;
  logic              above;
  logic              is_mark;

  always_comb begin
    word    = active_flat[seg_idx*WORD_W +: WORD_W];
    mag_ext = {1'b0, word[MAG_W-1:0]};
    is_mark = (sym_cur == SYM_POS) || (sym_cur == SYM_NEG);
    above   = word[WORD_W-1] ^ (sym_cur == SYM_NEG);
    if (!mode_cur || !is_mark) level = '0;
    else if (above)            level = mag_ext;
    else                       level = '0 - mag_ext;
  end
endmodule

// File: rtl/seg_pulse_shaper.sv
module seg_pulse_shaper #(
  parameter int NUM_SEG  = 8,
  parameter int WORD_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int SEG_BASE = 8,
  localparam int IDX_W   = $clog2(NUM_SEG),
  localparam int BANK_W  = NUM_SEG * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              t1_mode,
  input  logic              seg_stb,
  input  logic [1:0]        sym_req,
  output logic [IDX_W-1:0]  seg_num,
  output logic [WORD_W-1:0] sample_out
);
  logic              rst_sync_n;
  logic              wrap;
  logic [1:0]        sym_cur;
  logic              mode_cur;
  logic [BANK_W-1:0] active_flat;

  shp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shp_seq #(.NUM_SEG(NUM_SEG)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .seg_stb  (seg_stb),
    .sym_req  (sym_req),
    .t1_mode  (t1_mode),
    .seg_idx  (seg_num),
    .sym_cur  (sym_cur),
    .mode_cur (mode_cur),
    .wrap     (wrap)
  );

  shp_regbank #(
    .NUM_SEG(NUM_SEG), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEG_BASE(SEG_BASE)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .we          (host_we),
    .addr        (host_addr),
    .wdata       (host_wdata),
    .load        (wrap),
    .rdata       (host_rdata),
    .active_flat (active_flat)
  );

  shp_level #(.NUM_SEG(NUM_SEG), .WORD_W(WORD_W)) u_level (
    .active_flat (active_flat),
    .seg_idx     (seg_num),
    .sym_cur     (sym_cur),
    .mode_cur    (mode_cur),
    .level       (sample_out)
  );

  AST_SPACE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sym_cur == shp_pkg::SYM_SPACE || sym_cur == shp_pkg::SYM_RSV) |-> (sample_out == '0)); // R8
  AST_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_cur |-> (sample_out == '0)); // R9
endmodule

// File: tb/seg_pulse_shaper_test.sv
module seg_pulse_shaper_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_we;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       t1_mode;
  logic       seg_stb;
  logic [1:0] sym_req;
  logic [2:0] seg_num;
  logic [7:0] sample_out;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl_shd [8];
  logic [7:0] mdl_act [8];

  always #2.5 clk = ~clk;

  seg_pulse_shaper uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .t1_mode(t1_mode),
    .seg_stb(seg_stb), .sym_req(sym_req), .seg_num(seg_num), .sample_out(sample_out)
  );

  function automatic logic [7:0] exp_lvl(logic [7:0] w, logic [1:0] s, logic m);
    logic [7:0] mag;
    logic up;
    if (!m || !(s == 2'b01 || s == 2'b10)) return 8'h00;
    mag = {1'b0, w[6:0]};
    up  = w[7] ^ (s == 2'b10);
    return up ? mag : 8'h00 - mag;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    if (a >= 4'h8) mdl_shd[a - 4'h8] = d;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [7:0] exp);
    @(negedge clk);
    host_addr = a;
    #1;
    check(req, host_rdata, exp);
  endtask

  task automatic strobe();
    @(negedge clk);
    seg_stb = 1'b1;
    @(negedge clk);
    seg_stb = 1'b0;
  endtask

  // Sends one symbol; optional write after segment index mid_k; wrap_wr puts a write on the wrap cycle.
  task automatic run_symbol(string req, logic [1:0] s, logic m, int mid_k,
                            logic [3:0] wa, logic [7:0] wd, bit wrap_wr);
    @(negedge clk);
    sym_req = s; t1_mode = m; seg_stb = 1'b1;
    if (wrap_wr) begin host_we = 1'b1; host_addr = wa; host_wdata = wd; end
    @(negedge clk);
    seg_stb = 1'b0; host_we = 1'b0;
    for (int i = 0; i < 8; i++) mdl_act[i] = mdl_shd[i];
    if (wrap_wr) mdl_shd[wa - 4'h8] = wd;
    sym_req = ~s; t1_mode = ~m;
    for (int k = 0; k < 8; k++) begin
      check("R4", {5'b0, seg_num}, k[7:0]);
      check(req, sample_out, exp_lvl(mdl_act[k], s, m));
      if (k == mid_k) wr(wa, wd);
      if (k < 7) strobe();
    end
    sym_req = 2'b00; t1_mode = 1'b1;
  endtask

  task automatic t_reset();
    check("R1", sample_out, 8'h00);
    check("R1", {5'b0, seg_num}, 8'd7);
    for (int a = 8; a < 16; a++) rd_check("R1", a[3:0], 8'h00);
  endtask

  task automatic t_regs();
    for (int a = 8; a < 16; a++) wr(a[3:0], 8'h80 + 8'(a * 13));
    for (int a = 8; a < 16; a++) rd_check("R2", a[3:0], 8'h80 + 8'(a * 13));
    wr(4'hB, 8'h7F);
    rd_check("R2", 4'hB, 8'h7F);
  endtask

  task automatic t_unmapped();
    wr(4'h3, 8'hA5);
    wr(4'h0, 8'hFF);
    rd_check("R3", 4'h3, 8'h00);
    rd_check("R3", 4'h0, 8'h00);
    for (int a = 8; a < 16; a++) rd_check("R3", a[3:0], mdl_shd[a - 8]);
  endtask

  task automatic t_shape();
    wr(4'h8, 8'h85); wr(4'h9, 8'hFF); wr(4'hA, 8'hE0); wr(4'hB, 8'hC0);
    wr(4'hC, 8'h20); wr(4'hD, 8'h0A); wr(4'hE, 8'h80); wr(4'hF, 8'h00);
    run_symbol("R6", 2'b01, 1'b1, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R7", 2'b10, 1'b1, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R8", 2'b00, 1'b1, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R8", 2'b11, 1'b1, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R9", 2'b01, 1'b0, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R5", 2'b10, 1'b1, -1, 4'h8, 8'h00, 1'b0);
  endtask

  task automatic t_update();
    run_symbol("R10", 2'b01, 1'b1, 2, 4'hE, 8'hFE, 1'b0);
    run_symbol("R10", 2'b01, 1'b1, -1, 4'h8, 8'h00, 1'b0);
    run_symbol("R10", 2'b10, 1'b1, -1, 4'h9, 8'h11, 1'b1);
    run_symbol("R10", 2'b10, 1'b1, -1, 4'h8, 8'h00, 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    check("R4", {5'b0, seg_num}, 8'd7);
    repeat (3) @(negedge clk);
    check("R4", {5'b0, seg_num}, 8'd7);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    t1_mode = 1'b1; seg_stb = 1'b0; sym_req = 2'b00;
    for (int i = 0; i < 8; i++) begin mdl_shd[i] = 8'h00; mdl_act[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_shape();
    t_update();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule